// File: doc/BRIEF.md
# Banked General-Purpose I/O Controller with Edge Interrupts

This block gives a chip a parameterised set of general-purpose pins, 40 by default. The pins are grouped into 16-bit banks and controlled through a simple word-addressed register bus. Each pin has a direction bit and an input polarity-inversion bit. Its output latch has two ports: one register sets bits when a 1 is written, and another clears them. A 2-bit function code per pin decides whether the GPIO logic or an alternate-function peripheral owns the pad. That peripheral sits outside the block; the code is presented on `pin_func` for the pad multiplexer.

Every pin input passes through a two-flop synchroniser. Software reads the synchronised level, after inversion, at the bank's set-register address. The low sixteen pins can also raise interrupts. On each of these pins an optional chatter filter runs first, controlled by a per-pin enable and a shared tick count. An edge detector follows. It fires on both edges when the pin's both-edges bit is set. Otherwise it fires on one edge, chosen by the pin's inversion bit. Each detected edge sets a sticky pending bit, and `irq` is the OR of the pending bits whose enable is set.

The register bus is plain control: a write completes on the clock edge where `bus_wr` is high, and `bus_rdata` is a combinational view of the register selected by `bus_addr`. There is no back-pressure.

Top module: `gpio_banked`

## Requirements
- R1: After reset every pin is an input (direction bit 1) and non-inverted. Every function code is 0 (GPIO), the output latch is 0, all interrupt enables, both-edge bits, chatter enables and pending bits are 0, the chatter count is 0, and `irq` is low.
- R2: Pin n belongs to bank n/16 at bit n%16. A direction bit of 1 makes the pin an input and a 0 makes it an output. `pin_oe[n]` is high only when the direction bit is 0 and the function code is 0.
- R3: Writing 1 to a bit of a bank's set register drives that output latch bit to 1. Writing 1 to the same bit of the bank's clear register drives it to 0. Bits written as 0 leave the latch unchanged. A read of the clear register returns the latch, and `pin_out` shows the latch without inversion.
- R4: A read of a bank's set register returns the pin level after the two-flop synchroniser, XORed with the bank's inversion register. Bits above the last pin read 0.
- R5: Function codes are packed 8 per register, pin n in register n/8 at bits 2*(n%8)+1:2*(n%8), and a direct write replaces a whole register. A write to the field port updates only one pin: bits 5:0 carry the pin index and bits 9:8 carry the code. Any non-zero code clears `pin_oe` for that pin.
- R6: On the interrupt pins 0..15, a both-edges bit of 1 triggers on both edges of the filtered raw pin level. With the bit at 0, a falling edge triggers when the inversion bit is 0 and a rising edge triggers when the inversion bit is 1.
- R7: Pins 16 and above never set a pending bit.
- R8: A detected edge sets its pending bit whether or not the pin's interrupt is enabled. A pending bit stays set until a 1 is written to it at the pending address, and 0 bits in that write have no effect. `irq` is high exactly when some pending bit has its enable bit set.
- R9: With a pin's chatter enable set and a non-zero count N, a new level reaches the edge detector only after the synchronised input has held it for N consecutive clocks. A pulse of N-1 clocks is discarded and a pulse of N clocks is accepted. With a count of 0 or the enable clear, the filter is bypassed.
- R10: Word addresses are as follows. Each bank b has direction at 8b, inversion at 8b+1, set/input at 8b+2 and clear/latch at 8b+3. The global registers are interrupt enable at 24, both-edges at 25, pending at 26, chatter enable at 27, chatter count at 28 and the field port at 29. The packed function registers start at 32. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Pad input levels, asynchronous |
| pin_out | output | NUM_PINS | Output latch |
| pin_oe | output | NUM_PINS | Output enable, high when GPIO drives the pad |
| pin_func | output | 2*NUM_PINS | Function code per pin, pin n at bits 2n+1:2n |
| irq | output | 1 | Combined interrupt request |

## Verification
Edge detection is swept over every interrupt pin in all three edge modes with a rising and then a falling transition. This separates the falling, rising and both-edge selections and catches a swapped inversion sense. Input readback runs each bank through several level and inversion patterns, so a wrong bank mapping or inversion order shows up directly. The chatter filter is probed with pulses of exactly N-1 and N clocks, and again with the filter bypassed, to pin down the acceptance boundary. Set, clear and field-port writes walk every pin one at a time, so any write that disturbs a neighbouring bit is visible.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;
  localparam int REG_W          = 16;
  localparam int ADDR_W         = 6;
  localparam int BANK_STRIDE    = 8;
  localparam int FIELDS_PER_REG = REG_W / 2;
  localparam int IDX_W          = 6;

  typedef enum logic [1:0] {
    K_DIR = 2'd0,
    K_INV = 2'd1,
    K_SET = 2'd2,
    K_CLR = 2'd3
  } bank_kind_e;

  typedef enum logic [1:0] {
    FN_GPIO = 2'd0,
    FN_ALT1 = 2'd1,
    FN_ALT2 = 2'd2,
    FN_ALT3 = 2'd3
  } func_e;

  localparam logic [ADDR_W-1:0] A_IRQ_EN     = 6'd24;
  localparam logic [ADDR_W-1:0] A_BOTH       = 6'd25;
  localparam logic [ADDR_W-1:0] A_PEND       = 6'd26;
  localparam logic [ADDR_W-1:0] A_CHAT_EN    = 6'd27;
  localparam logic [ADDR_W-1:0] A_CHAT_CNT   = 6'd28;
  localparam logic [ADDR_W-1:0] A_FSEL_FIELD = 6'd29;
  localparam int                FSEL_BASE    = 32;

  function automatic logic [ADDR_W-1:0] bank_addr(input int pin, input bank_kind_e kind);
    return ADDR_W'((pin / REG_W) * BANK_STRIDE + int'(kind));
  endfunction

  function automatic logic [ADDR_W-1:0] fsel_addr(input int pin);
    return ADDR_W'(FSEL_BASE + pin / FIELDS_PER_REG);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 40,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             filt_on,
  input  logic [CNT_W-1:0] limit,
  input  logic             din,
  output logic             dout
);
  logic [CNT_W-1:0] run_q;
  logic             lvl_q;
  logic [CNT_W-1:0] run_nxt;
  logic             bypass;

  assign run_nxt = run_q + 1'b1;
  assign bypass  = !filt_on || (limit == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (bypass) begin
      lvl_q <= din;
      run_q <= '0;
    end else if (din == lvl_q) begin
      run_q <= '0;
    end else if (run_nxt == limit) begin
      lvl_q <= din;
      run_q <= '0;
    end else begin
      run_q <= run_nxt;
    end
  end

  assign dout = lvl_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int NUM_IRQ = 16,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] level_in,
  input  logic [NUM_IRQ-1:0] inv,
  input  logic [NUM_IRQ-1:0] both,
  input  logic [NUM_IRQ-1:0] en,
  input  logic [NUM_IRQ-1:0] chat_en,
  input  logic [CNT_W-1:0]   chat_limit,
  input  logic               clr_stb,
  input  logic [NUM_IRQ-1:0] clr_mask,
  output logic [NUM_IRQ-1:0] pending,
  output logic               irq
);
  logic [NUM_IRQ-1:0] filt;
  logic [NUM_IRQ-1:0] prev_q;
  logic [NUM_IRQ-1:0] hit;
  logic [NUM_IRQ-1:0] pend_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_pin
    gpio_debounce #(.CNT_W(CNT_W)) u_deb (
      .clk     (clk),
      .rst_n   (rst_n),
      .filt_on (chat_en[i]),
      .limit   (chat_limit),
      .din     (level_in[i]),
      .dout    (filt[i])
    );

    logic rise, fall;
    assign rise   = filt[i] & ~prev_q[i];
    assign fall   = ~filt[i] & prev_q[i];
    assign hit[i] = both[i] ? (rise | fall) : (inv[i] ? rise : fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= filt;
      pend_q <= (pend_q & ~(clr_stb ? clr_mask : '0)) | hit;
    end
  end

  assign pending = pend_q;
  assign irq     = |(pend_q & en);
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
  import gpio_banked_pkg::*;
#(
  parameter int NUM_PINS    = 40,
  parameter int NUM_IRQ     = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [REG_W-1:0]      bus_wdata,
  output logic [REG_W-1:0]      bus_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [2*NUM_PINS-1:0] pin_func,
  output logic                  irq
);
  localparam int FUNC_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] dir_q, inv_q, out_q;
  logic [FUNC_W-1:0]   func_q;
  logic [NUM_IRQ-1:0]  en_q, both_q, chat_en_q;
  logic [CNT_W-1:0]    chat_cnt_q;
  logic [NUM_PINS-1:0] sync_lvl;
  logic [NUM_PINS-1:0] in_view;
  logic [NUM_IRQ-1:0]  pending;
  logic                pend_clr;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (sync_lvl)
  );

  assign in_view  = sync_lvl ^ inv_q;
  assign pend_clr = bus_wr && (bus_addr == A_PEND);

  // per-pin bank registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      inv_q <= '0;
      out_q <= '0;
    end else if (bus_wr) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (bus_addr == bank_addr(p, K_DIR)) dir_q[p] <= bus_wdata[p % REG_W];
        if (bus_addr == bank_addr(p, K_INV)) inv_q[p] <= bus_wdata[p % REG_W];
        if (bus_addr == bank_addr(p, K_SET) && bus_wdata[p % REG_W]) out_q[p] <= 1'b1;
        else if (bus_addr == bank_addr(p, K_CLR) && bus_wdata[p % REG_W]) out_q[p] <= 1'b0;
      end
    end
  end

  // interrupt configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      both_q     <= '0;
      chat_en_q  <= '0;
      chat_cnt_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_IRQ_EN)   en_q       <= bus_wdata[NUM_IRQ-1:0];
      if (bus_addr == A_BOTH)     both_q     <= bus_wdata[NUM_IRQ-1:0];
      if (bus_addr == A_CHAT_EN)  chat_en_q  <= bus_wdata[NUM_IRQ-1:0];
      if (bus_addr == A_CHAT_CNT) chat_cnt_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // function select: packed registers and the single-field port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
    end else if (bus_wr) begin
      for (int f = 0; f < NUM_PINS; f++) begin
        if (bus_addr == fsel_addr(f))
          func_q[2*f +: 2] <= bus_wdata[2*(f % FIELDS_PER_REG) +: 2];
        else if (bus_addr == A_FSEL_FIELD && bus_wdata[IDX_W-1:0] == IDX_W'(f))
          func_q[2*f +: 2] <= bus_wdata[9:8];
      end
    end
  end

  gpio_irq_unit #(.NUM_IRQ(NUM_IRQ), .CNT_W(CNT_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_in   (sync_lvl[NUM_IRQ-1:0]),
    .inv        (inv_q[NUM_IRQ-1:0]),
    .both       (both_q),
    .en         (en_q),
    .chat_en    (chat_en_q),
    .chat_limit (chat_cnt_q),
    .clr_stb    (pend_clr),
    .clr_mask   (bus_wdata[NUM_IRQ-1:0]),
    .pending    (pending),
    .irq        (irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (bus_addr == bank_addr(p, K_DIR)) bus_rdata[p % REG_W] = dir_q[p];
      if (bus_addr == bank_addr(p, K_INV)) bus_rdata[p % REG_W] = inv_q[p];
      if (bus_addr == bank_addr(p, K_SET)) bus_rdata[p % REG_W] = in_view[p];
      if (bus_addr == bank_addr(p, K_CLR)) bus_rdata[p % REG_W] = out_q[p];
      if (bus_addr == fsel_addr(p))
        bus_rdata[2*(p % FIELDS_PER_REG) +: 2] = func_q[2*p +: 2];
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (bus_addr == A_IRQ_EN)  bus_rdata[i] = en_q[i];
      if (bus_addr == A_BOTH)    bus_rdata[i] = both_q[i];
      if (bus_addr == A_PEND)    bus_rdata[i] = pending[i];
      if (bus_addr == A_CHAT_EN) bus_rdata[i] = chat_en_q[i];
    end
    if (bus_addr == A_CHAT_CNT) bus_rdata[CNT_W-1:0] = chat_cnt_q;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    assign pin_oe[p] = ~dir_q[p] & (func_q[2*p +: 2] == FN_GPIO);
  end

  assign pin_out  = out_q;
  assign pin_func = func_q;
endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk
  import gpio_banked_pkg::*;
#(
  parameter int NUM_PINS = 40
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [REG_W-1:0]      bus_wdata,
  input logic [NUM_PINS-1:0]   pin_out,
  input logic [NUM_PINS-1:0]   pin_oe,
  input logic [2*NUM_PINS-1:0] pin_func,
  input logic                  irq
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_func == '0 && pin_out == '0 && !irq));

  assert_irq_drop_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr && (bus_addr == A_PEND || bus_addr == A_IRQ_EN)));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [ADDR_W-1:0] A_S = bank_addr(p, K_SET);
    localparam logic [ADDR_W-1:0] A_C = bank_addr(p, K_CLR);
    localparam logic [ADDR_W-1:0] A_D = bank_addr(p, K_DIR);
    localparam int B = p % REG_W;

    assert_set_drives_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_S && bus_wdata[B]) |=> pin_out[p]);

    assert_clr_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_C && bus_wdata[B]) |=> !pin_out[p]);

    assert_zero_write_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == A_S || bus_addr == A_C) && !bus_wdata[B]) |=> $stable(pin_out[p]));

    assert_input_releases_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_D && bus_wdata[B]) |=> !pin_oe[p]);

    assert_alt_func_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[p] |-> (pin_func[2*p +: 2] == FN_GPIO));
  end
endmodule

bind gpio_banked gpio_banked_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_func  (pin_func),
  .irq       (irq)
);

// File: tb/sim_gpio_banked.sv
module sim_gpio_banked;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 40;
  localparam logic [5:0] IRQ_EN = 6'd24, BOTH = 6'd25, PEND = 6'd26,
                         CHEN = 6'd27, CHCNT = 6'd28, FIELD = 6'd29;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [2*NP-1:0] pin_func;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;

  gpio_banked u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] a_bank(input int b, input int k);
    return 6'(b * 8 + k);
  endfunction

  function automatic logic [15:0] bank_mask(input int b);
    if (b * 16 + 16 <= NP) return 16'hFFFF;
    return 16'((32'h1 << (NP - b * 16)) - 1);
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int pin, input int len);
    @(negedge clk);
    pin_in[pin] = 1'b1;
    repeat (len) @(negedge clk);
    pin_in[pin] = 1'b0;
    settle(20);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic [NP-1:0] exp_out;
    logic [2*NP-1:0] exp_fn;

    settle(4);
    // R1 reset state
    rd(a_bank(0, 0), r); chk("R1 dir0", r, 16'hFFFF);
    rd(a_bank(2, 0), r); chk("R1 dir2 (R10 unused bits)", r, 16'h00FF);
    rd(a_bank(1, 1), r); chk("R1 inv1", r, 0);
    rd(PEND, r);         chk("R1 pending", r, 0);
    rd(CHCNT, r);        chk("R1 chatter count", r, 0);
    chk("R1 oe", pin_oe, 0);
    chk("R1 func", pin_func, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    settle(2);

    // R4 input readback through set address with inversion
    for (int b = 0; b < 3; b++) begin
      for (int t = 0; t < 4; t++) begin
        logic [15:0] pat, iv;
        pat = (t == 0) ? 16'h0000 : (t == 1) ? 16'hFFFF : (t == 2) ? 16'hA5C3 : 16'h1234;
        iv  = (t == 0) ? 16'h0F0F : (t == 1) ? 16'h0000 : (t == 2) ? 16'hFF00 : 16'h8421;
        for (int k = 0; k < 16; k++) if (b * 16 + k < NP) pin_in[b*16+k] = pat[k];
        wr(a_bank(b, 1), iv);
        settle(4);
        rd(a_bank(b, 2), r);
        chk("R4 readback", r, (pat ^ iv) & bank_mask(b));
      end
      wr(a_bank(b, 1), 16'h0000);
    end
    pin_in = '0;
    settle(4);
    wr(PEND, 16'hFFFF);

    // R2/R3 direction, set and clear per pin
    for (int b = 0; b < 3; b++) wr(a_bank(b, 0), 16'h0000);
    chk("R2 all outputs", pin_oe, {NP{1'b1}});
    exp_out = '0;
    for (int p = 0; p < NP; p++) begin
      exp_out[p] = 1'b1;
      wr(a_bank(p / 16, 2), 16'(1 << (p % 16)));
      chk("R3 set", pin_out, exp_out);
      if (p % 8 == 0) begin
        wr(a_bank(p / 16, 2), 16'h0000);
        wr(a_bank(p / 16, 3), 16'h0000);
        chk("R3 zero write", pin_out, exp_out);
      end
    end
    for (int b = 0; b < 3; b++) begin
      rd(a_bank(b, 3), r); chk("R3 latch readback", r, bank_mask(b));
    end
    for (int p = 0; p < NP; p += 3) begin
      exp_out[p] = 1'b0;
      wr(a_bank(p / 16, 3), 16'(1 << (p % 16)));
      chk("R3 clear", pin_out, exp_out);
    end
    wr(a_bank(1, 0), 16'h00F0);
    chk("R2 bank1 inputs", pin_oe[31:16], 16'hFF0F);

    // R5 function select
    wr(FIELD, 16'h0207);
    rd(6'd32, r); chk("R5 field write", r, 16'h8000);
    chk("R5 oe released", pin_oe[7], 1'b0);
    wr(6'd36, 16'h5555);
    chk("R5 packed write", pin_func[79:64], 16'h5555);
    chk("R5 alt pins no oe", pin_oe[39:32], 8'h00);
    wr(FIELD, 16'h0023);
    rd(6'd36, r); chk("R5 only field", r, 16'h5515);
    exp_fn = '0;
    for (int p = 0; p < NP; p++) begin
      wr(FIELD, 16'(((p % 4) << 8) | p));
      exp_fn[2*p +: 2] = 2'(p % 4);
    end
    chk("R5 all fields", pin_func, exp_fn);
    for (int p = 0; p < NP; p++) wr(FIELD, 16'(p));
    chk("R5 cleared", pin_func, 0);
    for (int b = 0; b < 3; b++) wr(a_bank(b, 0), 16'hFFFF);

    // R6/R8 edge sweep over all interrupt pins and modes
    wr(IRQ_EN, 16'hFFFF);
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 3; m++) begin  // 0 falling, 1 rising, 2 both
        logic [15:0] e;
        wr(a_bank(0, 1), (m == 1) ? 16'(1 << p) : 16'h0);
        wr(BOTH, (m == 2) ? 16'(1 << p) : 16'h0);
        wr(PEND, 16'hFFFF);
        pin_in[p] = 1'b1;
        settle(6);
        e = (m != 0) ? 16'(1 << p) : 16'h0;
        rd(PEND, r); chk("R6 after rise", r, e);
        chk("R8 irq after rise", irq, e != 0);
        pin_in[p] = 1'b0;
        settle(6);
        e = 16'(1 << p);
        rd(PEND, r); chk("R6 after fall", r, e);
      end
    end
    wr(IRQ_EN, 16'h0000);
    rd(PEND, r); chk("R8 pending kept while disabled", r, 16'h8000);
    chk("R8 irq masked", irq, 0);
    wr(IRQ_EN, 16'h8000);
    chk("R8 irq enabled", irq, 1);
    wr(PEND, 16'h7FFF);
    chk("R8 zero bits no clear", irq, 1);
    wr(PEND, 16'h8000);
    chk("R8 w1c", irq, 0);
    wr(a_bank(0, 1), 16'h0);
    wr(BOTH, 16'hFFFF);

    // R7 high pins never pend
    pin_in[NP-1:16] = '1;
    settle(8);
    pin_in[NP-1:16] = '0;
    settle(8);
    rd(PEND, r); chk("R7 no pending", r, 0);

    // R9 chatter filter
    wr(CHEN, 16'h0008);
    wr(CHCNT, 16'd8);
    pulse(3, 7);
    rd(PEND, r); chk("R9 short pulse ignored", r, 0);
    pulse(3, 8);
    rd(PEND, r); chk("R9 N pulse accepted", r, 16'h0008);
    wr(PEND, 16'hFFFF);
    pulse(4, 1);
    rd(PEND, r); chk("R9 unfiltered pin", r, 16'h0010);
    wr(PEND, 16'hFFFF);
    wr(CHCNT, 16'd0);
    pulse(3, 1);
    rd(PEND, r); chk("R9 zero count bypass", r, 16'h0008);

    // R10 map details
    wr(CHCNT, 16'h1234);
    rd(CHCNT, r); chk("R10 count readback", r, 16'h1234);
    wr(6'd30, 16'hFFFF);
    rd(6'd30, r); chk("R10 unmapped", r, 0);
    rd(FIELD, r); chk("R10 field port reads 0", r, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule